// File: doc/BRIEF.md
# Frame-Based Q15 FIR Multiply-Accumulate Engine

This block filters a stream of signed 16-bit fractional samples through a direct-form FIR with up to `MAX_TAPS` programmable coefficients. Work is organised in frames. A frame-start pulse carries the active tap count and the number of samples in the frame. The engine then takes that many samples over a valid/ready input, and for each one it returns exactly one filtered sample on a valid/ready output, in input order. A register file of past inputs survives from one frame to the next, so every frame carries on from the samples that came before it.

Each output sample is built by a two-lane multiply-accumulate datapath. On each cycle it forms two coefficient-by-sample products, doubles each product to drop the redundant sign bit, and adds both into an accumulator that has eight guard bits above a 32-bit main part. No overflow handling takes place during the sum. Only after the last tap does the engine either saturate to the 16-bit limits or take the upper half of the 32-bit part. A tap count that is odd, zero or above the maximum is rejected with an error flag, and that frame produces nothing.

Top module: `fir_frame_mac`

## Requirements
- R1: With tap count N, each output equals the sum over k = 0..N-1 of coef[k]·x(n-k), where x(n) is the newest accepted sample and x(n-k) is the sample accepted k samples earlier. Every product is multiplied by two before it is accumulated.
- R2: Accumulation uses a 40-bit signed register, cleared when each sample is accepted. Partial sums beyond the 32-bit range are kept exactly. When the final sum S lies within [-2^31, 2^31-1], the output is bits 31..16 of S (floor of S/65536, no rounding).
- R3: When the final sum exceeds 2^31-1 the output is 0x7FFF. When it is below -2^31 the output is 0x8000.
- R4: Two taps are processed per cycle. `outValid` rises N/2 clock edges after the edge that accepts the sample.
- R5: A frame start with a tap count that is odd, zero or greater than `MAX_TAPS` sets `tapErr`. Afterwards `inReady` and `outValid` stay low and the history is left unchanged until a frame start with a legal tap count arrives, and that frame start clears `tapErr`.
- R6: After reset every history entry is zero. History persists across frames and only changes when a sample is accepted.
- R7: A legal frame accepts exactly `frameLen` samples and emits exactly one output per sample, in order. One sample is in flight at a time. `inReady` is low outside a frame and while a sample is being computed.
- R8: While `outValid` is high and `outReady` is low, `outValid` and `outData` hold their values.
- R9: Writing `coefData` with `coefWe` high stores it as coefficient index `coefAddr`. All coefficients are zero after reset.
- R10: A frame start that arrives while a frame is in progress is ignored: neither the tap count nor `tapErr` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| coefWe | input | 1 | Coefficient write strobe |
| coefAddr | input | $clog2(MAX_TAPS) | Coefficient index to write |
| coefData | input | DATA_W | Q15 coefficient value |
| frameStart | input | 1 | Frame start pulse; samples tap count and frame length |
| numTaps | input | $clog2(MAX_TAPS+1) | Tap count for the frame |
| frameLen | input | FRAME_W | Number of samples in the frame |
| inValid | input | 1 | Input sample valid |
| inData | input | DATA_W | Q15 input sample |
| inReady | output | 1 | Engine accepts an input sample |
| outValid | output | 1 | Output sample valid |
| outData | output | DATA_W | Q15 filtered sample |
| outReady | input | 1 | Downstream accepts the output sample |
| tapErr | output | 1 | Last frame start carried an illegal tap count |

## Verification
The bench builds the engine with `MAX_TAPS` = 8 and a 6-bit frame length. At this size every even tap count from 2 to 8 can be swept, and every illegal count that the 4-bit tap field can carry (odd values, zero, and values above eight) can be tried as well. Full-scale coefficient and sample patterns at this size drive the sum well past ±2^31, which exercises both saturation limits and a case where a partial sum leaves the 32-bit range but the final sum comes back inside it. Because history is only eight entries deep, the effect of history carrying from one frame into the next shows up within a few samples.

// File: rtl/fir_mac_pkg.sv
package fir_mac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_MAC,
    ST_OUT
  } macState_e;

  typedef struct packed {
    logic pushSample;
    logic clrAcc;
    logic macStep;
  } macStrobe_t;

endpackage

// File: rtl/fir_mac_ctrl.sv
module fir_mac_ctrl
  import fir_mac_pkg::*;
#(
  parameter int MAX_TAPS = 80,
  parameter int FRAME_W  = 8,
  localparam int TAP_W   = $clog2(MAX_TAPS + 1),
  localparam int PAIRS   = MAX_TAPS / 2,
  localparam int PAIR_W  = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic [TAP_W-1:0]   numTaps,
  input  logic [FRAME_W-1:0] frameLen,
  input  logic               inValid,
  input  logic               outReady,
  output logic               inReady,
  output logic               outValid,
  output logic               tapErr,
  output macStrobe_t         strb,
  output logic [PAIR_W-1:0]  pairIdx
);

  localparam logic [TAP_W-1:0] MAX_TAPS_V = TAP_W'(MAX_TAPS);

  macState_e          state;
  logic [PAIR_W-1:0]  lastPair;
  logic [FRAME_W-1:0] remain;
  logic               tapsLegal;
  logic [TAP_W-1:0]   tapsHalf;

  assign tapsLegal = (numTaps != '0) && !numTaps[0] && (numTaps <= MAX_TAPS_V);
  assign tapsHalf  = numTaps >> 1;

  assign inReady  = (state == ST_WAIT);
  assign outValid = (state == ST_OUT);

  always_comb begin
    strb            = '0;
    strb.pushSample = (state == ST_WAIT) && inValid;
    strb.clrAcc     = (state == ST_WAIT) && inValid;
    strb.macStep    = (state == ST_MAC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      lastPair <= '0;
      remain   <= '0;
      pairIdx  <= '0;
      tapErr   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (frameStart) begin
            if (!tapsLegal) begin
              tapErr <= 1'b1;
            end else begin
              tapErr   <= 1'b0;
              lastPair <= PAIR_W'(tapsHalf - TAP_W'(1));
              remain   <= frameLen;
              if (frameLen != '0) state <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (inValid) begin
            pairIdx <= '0;
            state   <= ST_MAC;
          end
        end
        ST_MAC: begin
          if (pairIdx == lastPair) state <= ST_OUT;
          else pairIdx <= pairIdx + PAIR_W'(1);
        end
        ST_OUT: begin
          if (outReady) begin
            remain <= remain - FRAME_W'(1);
            state  <= (remain == FRAME_W'(1)) ? ST_IDLE : ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: a rejected tap count keeps the engine quiet
  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    tapErr |-> (!inReady && !outValid));

  // R4: the pair counter never runs past the last pair of the frame
  assert_pair_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MAC) |-> (pairIdx <= lastPair));

  // R7: the last accepted output closes the frame
  assert_frame_end_R7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && remain == FRAME_W'(1)) |=> (state == ST_IDLE));

endmodule

// File: rtl/fir_mac_datapath.sv
module fir_mac_datapath
  import fir_mac_pkg::*;
#(
  parameter int MAX_TAPS = 80,
  parameter int DATA_W   = 16,
  parameter int GUARD_W  = 8,
  localparam int ACC_W   = 2 * DATA_W + GUARD_W,
  localparam int PROD_W  = 2 * DATA_W,
  localparam int COEF_AW = $clog2(MAX_TAPS),
  localparam int PAIRS   = MAX_TAPS / 2,
  localparam int PAIR_W  = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coefWe,
  input  logic [COEF_AW-1:0] coefAddr,
  input  logic [DATA_W-1:0] coefData,
  input  logic [DATA_W-1:0] inData,
  input  macStrobe_t        strb,
  input  logic [PAIR_W-1:0] pairIdx,
  output logic [DATA_W-1:0] outData
);

  localparam logic [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W-1:0] coefMem [MAX_TAPS];
  logic signed [DATA_W-1:0] histReg [MAX_TAPS];
  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  laneTerm [2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_TAPS; i++) coefMem[i] <= '0;
    end else if (coefWe && (32'(coefAddr) < MAX_TAPS)) begin
      coefMem[coefAddr] <= coefData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_TAPS; i++) histReg[i] <= '0;
    end else if (strb.pushSample) begin
      histReg[0] <= inData;
      for (int i = 1; i < MAX_TAPS; i++) histReg[i] <= histReg[i-1];
    end
  end

  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    logic [PAIR_W:0]          tapIdx;
    logic signed [PROD_W-1:0] prod;
    assign tapIdx = {pairIdx, 1'(lane)};
    assign prod   = coefMem[tapIdx] * histReg[tapIdx];
    assign laneTerm[lane] = {{(GUARD_W-1){prod[PROD_W-1]}}, prod, 1'b0};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acc <= '0;
    else if (strb.clrAcc) acc <= '0;
    else if (strb.macStep) acc <= acc + laneTerm[0] + laneTerm[1];
  end

  logic guardOk;
  assign guardOk = (&acc[ACC_W-1:PROD_W-1]) || !(|acc[ACC_W-1:PROD_W-1]);

  always_comb begin
    if (guardOk) outData = acc[PROD_W-1:DATA_W];
    else if (acc[ACC_W-1]) outData = NEG_LIM;
    else outData = POS_LIM;
  end

  // R6: accepting a sample moves the newest entry one place back
  assert_hist_shift_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushSample |=> (histReg[1] == $past(histReg[0])));

  // R5: without an accepted sample the newest history entry stays put
  assert_hist_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.pushSample |=> $stable(histReg[0]));

  // R2: the sum is frozen once the tap loop has stopped
  assert_acc_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.macStep && !strb.clrAcc) |=> $stable(acc));

endmodule

// File: rtl/fir_frame_mac.sv
module fir_frame_mac
  import fir_mac_pkg::*;
#(
  parameter int MAX_TAPS = 80,
  parameter int DATA_W   = 16,
  parameter int GUARD_W  = 8,
  parameter int FRAME_W  = 8,
  localparam int COEF_AW = $clog2(MAX_TAPS),
  localparam int TAP_W   = $clog2(MAX_TAPS + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               coefWe,
  input  logic [COEF_AW-1:0] coefAddr,
  input  logic [DATA_W-1:0]  coefData,
  input  logic               frameStart,
  input  logic [TAP_W-1:0]   numTaps,
  input  logic [FRAME_W-1:0] frameLen,
  input  logic               inValid,
  input  logic [DATA_W-1:0]  inData,
  output logic               inReady,
  output logic               outValid,
  output logic [DATA_W-1:0]  outData,
  input  logic               outReady,
  output logic               tapErr
);

  localparam int PAIRS  = MAX_TAPS / 2;
  localparam int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  macStrobe_t        strb;
  logic [PAIR_W-1:0] pairIdx;

  fir_mac_ctrl #(
    .MAX_TAPS(MAX_TAPS),
    .FRAME_W (FRAME_W)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .numTaps   (numTaps),
    .frameLen  (frameLen),
    .inValid   (inValid),
    .outReady  (outReady),
    .inReady   (inReady),
    .outValid  (outValid),
    .tapErr    (tapErr),
    .strb      (strb),
    .pairIdx   (pairIdx)
  );

  fir_mac_datapath #(
    .MAX_TAPS(MAX_TAPS),
    .DATA_W  (DATA_W),
    .GUARD_W (GUARD_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .coefWe  (coefWe),
    .coefAddr(coefAddr),
    .coefData(coefData),
    .inData  (inData),
    .strb    (strb),
    .pairIdx (pairIdx),
    .outData (outData)
  );

  // R8: a stalled output keeps its value
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

endmodule

// File: tb/fir_frame_mac_tb.sv
module fir_frame_mac_tb_top;

  localparam int MAX_TAPS = 8;
  localparam int DATA_W   = 16;
  localparam int FRAME_W  = 6;
  localparam int COEF_AW  = $clog2(MAX_TAPS);
  localparam int TAP_W    = $clog2(MAX_TAPS + 1);

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               coefWe = 1'b0;
  logic [COEF_AW-1:0] coefAddr = '0;
  logic [DATA_W-1:0]  coefData = '0;
  logic               frameStart = 1'b0;
  logic [TAP_W-1:0]   numTaps = '0;
  logic [FRAME_W-1:0] frameLen = '0;
  logic               inValid = 1'b0;
  logic [DATA_W-1:0]  inData = '0;
  logic               inReady;
  logic               outValid;
  logic [DATA_W-1:0]  outData;
  logic               outReady = 1'b1;
  logic               tapErr;

  always #2 clk = ~clk;

  fir_frame_mac #(
    .MAX_TAPS(MAX_TAPS),
    .DATA_W  (DATA_W),
    .GUARD_W (8),
    .FRAME_W (FRAME_W)
  ) dut_i (
    .clk(clk), .rstN(rstN), .coefWe(coefWe), .coefAddr(coefAddr),
    .coefData(coefData), .frameStart(frameStart), .numTaps(numTaps),
    .frameLen(frameLen), .inValid(inValid), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outData(outData),
    .outReady(outReady), .tapErr(tapErr)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int coefModel [MAX_TAPS];
  int histModel [MAX_TAPS];
  int expQ [$];
  int outCount = 0;
  int curTaps = 2;
  string curReq = "R1";
  bit bpMode = 0;
  int cyc = 0;
  int seed = 32'h1234_5678;
  bit heldPending = 0;
  logic [DATA_W-1:0] heldVal = '0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int nextRand();
    seed = seed * 1103515245 + 12345;
    return int'($signed(seed[30:15]));
  endfunction

  function automatic int modelOut(input int taps);
    longint s = 0;
    for (int k = 0; k < taps; k++) s += 2 * (longint'(coefModel[k]) * longint'(histModel[k]));
    if (s > 64'sd2147483647) return 32767;
    if (s < -64'sd2147483648) return -32768;
    return int'(s >>> 16);
  endfunction

  task automatic writeCoef(input int idx, input int val);
    @(negedge clk);
    coefWe = 1'b1; coefAddr = COEF_AW'(idx); coefData = DATA_W'(val);
    @(negedge clk);
    coefWe = 1'b0;
    coefModel[idx] = val;
  endtask

  // mode 0: pseudo-random, 1: constant val, 2: alternating val / -val-1
  task automatic sendFrame(input int taps, input int len, input int mode,
                           input int val, input bit midStart);
    int lat;
    int startCount;
    curTaps = taps;
    startCount = outCount;
    @(negedge clk);
    frameStart = 1'b1; numTaps = TAP_W'(taps); frameLen = FRAME_W'(len);
    @(negedge clk);
    frameStart = 1'b0;
    check("R5 tapErr clear on legal start", int'(tapErr), 0);
    for (int i = 0; i < len; i++) begin
      int x;
      if (midStart && i == 1) begin
        frameStart = 1'b1; numTaps = TAP_W'(3);
        @(negedge clk);
        frameStart = 1'b0; numTaps = TAP_W'(taps);
        check("R10 mid-frame start ignored", int'(tapErr), 0);
      end
      case (mode)
        0: x = nextRand();
        1: x = val;
        default: x = (i % 2 == 0) ? val : (-val - 1);
      endcase
      for (int k = MAX_TAPS - 1; k > 0; k--) histModel[k] = histModel[k-1];
      histModel[0] = x;
      expQ.push_back(modelOut(taps));
      inValid = 1'b1; inData = DATA_W'(x);
      while (!inReady) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      inValid = 1'b0;
      lat = 1;
      while (!outValid && lat < 100) begin @(negedge clk); lat++; end
      check("R4 output latency", lat, taps / 2 + 1);
      while (!(outValid && outReady)) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
    end
    check("R7 outputs per frame", outCount - startCount, len);
    check("R7 inReady low after frame", int'(inReady), 0);
  endtask

  task automatic badStart(input int taps);
    @(negedge clk);
    frameStart = 1'b1; numTaps = TAP_W'(taps); frameLen = FRAME_W'(4);
    @(negedge clk);
    frameStart = 1'b0;
    check("R5 tapErr set", int'(tapErr), 1);
    inValid = 1'b1; inData = 16'h1234;
    begin
      int busy = 0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (inReady || outValid) busy++;
      end
      check("R5 no accept/no output after bad start", busy, 0);
    end
    inValid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    outReady <= !bpMode || (cyc % 3 == 0);
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (heldPending) begin
        check("R8 valid held", int'(outValid), 1);
        check("R8 data held", int'(outData), int'(heldVal));
      end
      heldPending = outValid && !outReady;
      heldVal = outData;
      if (outValid && outReady) begin
        int e;
        e = (expQ.size() > 0) ? expQ.pop_front() : 99999;
        check(curReq, int'($signed(outData)), e);
        outCount++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < MAX_TAPS; k++) begin coefModel[k] = 0; histModel[k] = 0; end
    repeat (3) @(negedge clk);
    check("R7 reset outValid", int'(outValid), 0);
    check("R7 reset inReady", int'(inReady), 0);
    check("R5 reset tapErr", int'(tapErr), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R9: coefficients are zero after reset, outputs must be zero
    curReq = "R9 zero coefficients";
    sendFrame(4, 4, 0, 0, 0);

    // R6: first non-zero frame sees zero-initialised history remains, then carries over
    for (int k = 0; k < MAX_TAPS; k++) writeCoef(k, nextRand());
    curReq = "R1 R6 filter output";
    for (int t = 2; t <= MAX_TAPS; t += 2) sendFrame(t, 6, 0, 0, t == 4);
    sendFrame(8, 4, 2, 12000, 0);

    // R5: illegal tap counts across the whole 4-bit field
    for (int t = 0; t < 16; t++)
      if (t == 0 || (t % 2 == 1) || t > MAX_TAPS) badStart(t);
    curReq = "R5 R6 history untouched by rejected frames";
    sendFrame(8, 3, 0, 0, 0);

    // R3: full-scale saturation both ways
    for (int k = 0; k < MAX_TAPS; k++) writeCoef(k, 32767);
    curReq = "R3 positive saturation";
    sendFrame(8, 9, 1, 32767, 0);
    curReq = "R3 negative saturation";
    sendFrame(8, 9, 1, -32768, 0);

    // R2: partial sum leaves 32 bits, final sum returns in range
    for (int k = MAX_TAPS / 2; k < MAX_TAPS; k++) writeCoef(k, -32768);
    curReq = "R2 guard bits";
    sendFrame(8, 9, 1, 32767, 0);

    // R3: most negative times most negative
    writeCoef(0, -32768);
    writeCoef(1, 0);
    curReq = "R3 min times min";
    sendFrame(2, 3, 1, -32768, 0);

    // R8: output backpressure
    for (int k = 0; k < MAX_TAPS; k++) writeCoef(k, nextRand());
    bpMode = 1;
    curReq = "R1 R8 under backpressure";
    sendFrame(6, 5, 0, 0, 0);
    sendFrame(8, 4, 2, 30000, 0);
    bpMode = 0;
    repeat (4) @(negedge clk);

    check("R7 no stray outputs", expQ.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule